// File: doc/BRIEF.md
# Antenna Sample Ingress Scheduler

This block is the write-only entry point for time-interleaved antenna samples. In every sample period a streaming master writes one 16-bit word per antenna, starting with antenna 0 and going up in order. Each word carries a signed Q part in its upper byte and a signed I part in its lower byte. A free-running cycle counter divides the sample period into slots. Antenna k may be accepted only in slot k. The cycles after the last antenna slot are dead cycles, in which nothing is accepted. A master that writes too early is therefore held off. A master that is late freezes the counter in its slot until the word arrives.

Each accepted word is steered to its antenna's output lane. That lane gives a one-cycle strobe together with the registered I and Q values. Frame alignment uses a handshake. After reset the block raises a sync-wait interrupt and takes only antenna-0 words. It drops antenna-0 words whose info flag is clear. When an antenna-0 word with the info flag set is accepted, the interrupt clears and a slot-sync pulse goes out alongside that word.

Top module: `ingr_ant_ingress`

## Requirements
- R1: An accepted word sets the lane's Q output from bits 15:8 and its I output from bits 7:0. Only the low QW bits of each byte are used, and both values are two's-complement.
- R2: The write command is 1 bit, where 0 means idle and 1 means write. Accept is high only when a write is offered in slot k, for k below NUM_ANT, and the word taken there belongs to antenna k. After the last antenna slot, the period has PERIOD minus NUM_ANT dead cycles, where PERIOD is CLK_PER_CHIP divided by OVERSAMPLE.
- R3: A write offered during dead cycles is not accepted until the counter wraps back to slot 0.
- R4: If no write is offered in an antenna slot, the counter holds in that slot. The next write goes to that same antenna, and the dead-cycle count after the last antenna does not change.
- R5: After reset the sync-wait interrupt is 1. While it is 1, antenna-0 words with the info flag clear are accepted and then dropped: no strobe is produced and the schedule stays at slot 0.
- R6: When an antenna-0 word with the info flag set is accepted, the interrupt reads 0 from the next cycle on. In that same next cycle, slot_sync pulses together with the antenna-0 strobe.
- R7: Each word that is accepted and kept gives exactly one strobe, one cycle later, on its own lane only. At most one lane strobes in any cycle.
- R8: The info flag on a word for a nonzero antenna has no effect. The word is delivered normally, no slot_sync pulse appears, and the interrupt does not change.
- R9: During and right after reset, all strobes and slot_sync are 0, the interrupt is 1, and the schedule starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Command: 0 idle, 1 write |
| wr_data | input | 16 | Q in 15:8, I in 7:0 |
| wr_info | input | 1 | Frame-sync flag, meaningful on antenna 0 |
| wr_accept | output | 1 | Word taken this cycle |
| sync_wait_irq | output | 1 | High while frame sync is awaited |
| samp_i | output | NUM_ANT*QW | Per-lane I samples, lane k at k*QW |
| samp_q | output | NUM_ANT*QW | Per-lane Q samples, lane k at k*QW |
| samp_valid | output | NUM_ANT | One-cycle strobe per lane |
| slot_sync | output | 1 | Pulse with the synced antenna-0 sample |

## Verification
Some rules are checked by assertions on every cycle:
- at most one lane strobes per cycle;
- a slot_sync pulse always comes with the antenna-0 strobe;
- the counter does not move while its antenna slot goes unserved;
- the interrupt never rises again once it has cleared, and it only clears after an accepted synced word.

The bench scenarios have to show the rest: the exact number of dead cycles an early master waits, that a stall shifts the whole schedule, that unsynced words are dropped, that byte fields go to the right lanes, and that the info flag on other antennas is ignored.

// File: rtl/ingr_pkg.sv
package ingr_pkg;
  typedef enum logic {
    CMD_IDLE  = 1'b0,
    CMD_WRITE = 1'b1
  } ingr_cmd_e;

  localparam int WORD_W = 16;
  localparam int HALF_W = 8;
endpackage

// File: rtl/ingr_slot_sched.sv
module ingr_slot_sched #(
  parameter int PERIOD  = 10,
  parameter int NUM_ANT = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_cmd,
  input  logic                                 hold0,
  output logic                                 slot_open,
  output logic                                 accept,
  output logic [(NUM_ANT > 1 ? $clog2(NUM_ANT) : 1)-1:0] slot_idx
);
  import ingr_pkg::*;
  localparam int CYC_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int ANT_W = (NUM_ANT > 1) ? $clog2(NUM_ANT) : 1;
  localparam logic [CYC_W-1:0] LAST_ANT = CYC_W'(NUM_ANT - 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(PERIOD - 1);

  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] cyc_nxt;

  assign slot_open = (cyc <= LAST_ANT);
  assign accept    = slot_open && (wr_cmd == CMD_WRITE);
  assign slot_idx  = ANT_W'(cyc);
  assign cyc_nxt   = (cyc == LAST_CYC) ? '0 : cyc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0;
    end else if (!slot_open) begin
      cyc <= cyc_nxt;
    end else if (accept && !hold0) begin
      cyc <= cyc_nxt;
    end
  end

  // R4: an unserved antenna slot freezes the counter
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (slot_open && !accept) |=> $stable(cyc));
endmodule

// File: rtl/ingr_sync_track.sv
module ingr_sync_track (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic is_ant0,
  input  logic info,
  output logic waiting,
  output logic drop,
  output logic sync_hit
);
  logic take0;

  assign take0    = accept && is_ant0;
  assign drop     = waiting && take0 && !info;
  assign sync_hit = take0 && info;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b1;
    end else if (sync_hit) begin
      waiting <= 1'b0;
    end
  end

  // R6: interrupt clears only after an accepted synced antenna-0 word
  p_clear_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(waiting) |-> $past(accept && is_ant0 && info));
  // R5: once cleared, the wait state never comes back without reset
  p_no_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> !$rose(waiting));
endmodule

// File: rtl/ingr_lane_demux.sv
module ingr_lane_demux #(
  parameter int NUM_ANT = 4,
  parameter int QW      = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 accept,
  input  logic                                 drop,
  input  logic                                 sync_hit,
  input  logic [(NUM_ANT > 1 ? $clog2(NUM_ANT) : 1)-1:0] slot_idx,
  input  logic [15:0]                          wr_data,
  output logic [NUM_ANT*QW-1:0]                samp_i,
  output logic [NUM_ANT*QW-1:0]                samp_q,
  output logic [NUM_ANT-1:0]                   samp_valid,
  output logic                                 slot_sync
);
  import ingr_pkg::*;
  localparam int ANT_W = (NUM_ANT > 1) ? $clog2(NUM_ANT) : 1;

  logic keep;
  assign keep = accept && !drop;

  for (genvar k = 0; k < NUM_ANT; k++) begin : g_lane
    logic hit;
    assign hit = keep && (slot_idx == ANT_W'(k));
    always_ff @(posedge clk) begin
      if (rst) begin
        samp_valid[k]         <= 1'b0;
        samp_i[k*QW +: QW]    <= '0;
        samp_q[k*QW +: QW]    <= '0;
      end else begin
        samp_valid[k] <= hit;
        if (hit) begin
          samp_i[k*QW +: QW] <= wr_data[QW-1:0];
          samp_q[k*QW +: QW] <= wr_data[HALF_W +: QW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slot_sync <= 1'b0;
    else     slot_sync <= sync_hit;
  end

  // R7: never more than one lane strobes per cycle
  p_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(samp_valid));
  // R6: slot sync always travels with the antenna-0 sample
  p_sync_lane0_r6: assert property (@(posedge clk) disable iff (rst)
    slot_sync |-> samp_valid[0]);
endmodule

// File: rtl/ingr_ant_ingress.sv
module ingr_ant_ingress #(
  parameter int CLK_PER_CHIP = 20,
  parameter int OVERSAMPLE   = 2,
  parameter int NUM_ANT      = 4,
  parameter int QW           = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_cmd,
  input  logic [15:0]           wr_data,
  input  logic                  wr_info,
  output logic                  wr_accept,
  output logic                  sync_wait_irq,
  output logic [NUM_ANT*QW-1:0] samp_i,
  output logic [NUM_ANT*QW-1:0] samp_q,
  output logic [NUM_ANT-1:0]    samp_valid,
  output logic                  slot_sync
);
  localparam int PERIOD = CLK_PER_CHIP / OVERSAMPLE;
  localparam int ANT_W  = (NUM_ANT > 1) ? $clog2(NUM_ANT) : 1;

  logic             slot_open;
  logic [ANT_W-1:0] slot_idx;
  logic             drop;
  logic             sync_hit;

  ingr_slot_sched #(.PERIOD(PERIOD), .NUM_ANT(NUM_ANT)) u_sched (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .hold0(drop),
    .slot_open(slot_open), .accept(wr_accept), .slot_idx(slot_idx)
  );

  ingr_sync_track u_sync (
    .clk(clk), .rst(rst), .accept(wr_accept),
    .is_ant0(slot_idx == '0), .info(wr_info),
    .waiting(sync_wait_irq), .drop(drop), .sync_hit(sync_hit)
  );

  ingr_lane_demux #(.NUM_ANT(NUM_ANT), .QW(QW)) u_demux (
    .clk(clk), .rst(rst), .accept(wr_accept), .drop(drop),
    .sync_hit(sync_hit), .slot_idx(slot_idx), .wr_data(wr_data),
    .samp_i(samp_i), .samp_q(samp_q), .samp_valid(samp_valid),
    .slot_sync(slot_sync)
  );

  // R2: accept only ever answers an offered write
  p_accept_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    wr_accept |-> wr_cmd);
endmodule

// File: tb/ingr_ant_ingress_tb_top.sv
module ingr_ant_ingress_tb_top;
  localparam int NUM_ANT = 4;
  localparam int QW      = 8;
  localparam int PERIOD  = 10;
  localparam int DEAD    = PERIOD - NUM_ANT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_cmd = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_info = 1'b0;
  logic wr_accept, sync_wait_irq, slot_sync;
  logic [NUM_ANT*QW-1:0] samp_i, samp_q;
  logic [NUM_ANT-1:0] samp_valid;

  always #10 clk = ~clk;

  ingr_ant_ingress #(.CLK_PER_CHIP(20), .OVERSAMPLE(2), .NUM_ANT(NUM_ANT), .QW(QW)) dut_i (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_data(wr_data), .wr_info(wr_info),
    .wr_accept(wr_accept), .sync_wait_irq(sync_wait_irq), .samp_i(samp_i),
    .samp_q(samp_q), .samp_valid(samp_valid), .slot_sync(slot_sync)
  );

  typedef struct { int ant; logic [7:0] i; logic [7:0] q; bit sync; } exp_t;
  exp_t exp_q[$];
  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // driver: offer a word at a negedge, wait for accept, push expectation
  task automatic put(input logic [15:0] d, input bit info, input int ant,
                     input bit keep, input bit sync, output int waited);
    exp_t e;
    wr_cmd = 1'b1; wr_data = d; wr_info = info;
    #1;
    waited = 0;
    while (!wr_accept) begin
      @(negedge clk); #1; waited++;
    end
    if (keep) begin
      e.ant = ant; e.i = d[7:0]; e.q = d[15:8]; e.sync = sync;
      exp_q.push_back(e);
    end
    @(negedge clk);
    wr_cmd = 1'b0; wr_info = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every strobe with the scoreboard head
  always @(negedge clk) begin
    #2;
    if (!rst && |samp_valid) begin
      int cnt;
      int lane;
      exp_t e;
      cnt = 0; lane = -1;
      for (int k = 0; k < NUM_ANT; k++) if (samp_valid[k]) begin cnt++; lane = k; end
      chk("R7", "strobe count", cnt, 1);
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R5/R7 unexpected strobe actual=lane%0d expected=none", lane);
      end else begin
        e = exp_q.pop_front();
        chk("R2", "lane", lane, e.ant);
        chk("R1", "I value", int'(samp_i[lane*QW +: QW]), int'(e.i));
        chk("R1", "Q value", int'(samp_q[lane*QW +: QW]), int'(e.q));
        chk(e.sync ? "R6" : "R8", "slot_sync", int'(slot_sync), int'(e.sync));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9", "samp_valid", int'(samp_valid), 0);
    chk("R9", "slot_sync", int'(slot_sync), 0);
    chk("R9", "irq", int'(sync_wait_irq), 1);
    chk("R9", "accept idle", int'(wr_accept), 0);
    // R5 unsynced antenna-0 words dropped, schedule stays at slot 0
    put(16'h11A1, 1'b0, 0, 1'b0, 1'b0, w); chk("R5", "wait drop1", w, 0);
    idle(2);
    chk("R5", "irq still set", int'(sync_wait_irq), 1);
    put(16'h1234, 1'b0, 0, 1'b0, 1'b0, w); chk("R5", "wait drop2", w, 0);
    // R6 synced word
    put(16'h2202, 1'b1, 0, 1'b1, 1'b1, w); chk("R6", "wait sync", w, 0);
    chk("R6", "irq cleared", int'(sync_wait_irq), 0);
    put(16'h80FF, 1'b0, 1, 1'b1, 1'b0, w); chk("R2", "wait a1", w, 0);
    put(16'h4404, 1'b1, 2, 1'b1, 1'b0, w); chk("R8", "wait a2 info", w, 0);
    chk("R8", "irq unchanged", int'(sync_wait_irq), 0);
    put(16'h7F80, 1'b0, 3, 1'b1, 1'b0, w); chk("R2", "wait a3", w, 0);
    // R3 early write held across dead cycles
    put(16'h6606, 1'b0, 0, 1'b1, 1'b0, w); chk("R3", "early wait", w, DEAD);
    // R4 late data stalls the schedule
    idle(3);
    put(16'hA5C3, 1'b0, 1, 1'b1, 1'b0, w); chk("R4", "late a1", w, 0);
    put(16'h0110, 1'b0, 2, 1'b1, 1'b0, w); chk("R4", "a2 after stall", w, 0);
    put(16'hFE01, 1'b0, 3, 1'b1, 1'b0, w); chk("R4", "a3 after stall", w, 0);
    put(16'h3C3C, 1'b0, 0, 1'b1, 1'b0, w); chk("R4", "dead kept", w, DEAD);
    put(16'h0A0B, 1'b0, 1, 1'b1, 1'b0, w);
    put(16'h0C0D, 1'b0, 2, 1'b1, 1'b0, w);
    put(16'h0E0F, 1'b0, 3, 1'b1, 1'b0, w);
    // R3 partial dead time already elapsed
    idle(2);
    put(16'h5A5A, 1'b1, 0, 1'b1, 1'b1, w); chk("R3", "wait after idle", w, DEAD - 2);
    idle(3);
    chk("R7", "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule